// File: doc/BRIEF.md
# I2C Byte Receiver with Acknowledge and Clock-Stretch Control

This block is the byte-level receive path of an I2C node. It watches SCL and SDA after they have been synchronised to the system clock. It counts SCL pulses, shifts in eight data bits most-significant first, raises a receive-full flag and drives the acknowledge slot on the ninth clock from a programmable value. It also records the acknowledge level that is seen on the bus during that ninth clock. It can stretch SCL at two points: after the eighth clock, so that software can pick the acknowledge value before it goes out, and between bytes. Every hold ends when the host strobes a data read.

An 8-bit control and status register configures the block. The acknowledge value held in that register can only be changed by a write that also sets a write-enable bit in the same word. The filter-select and bus-type fields are stored and passed on to the neighbouring blocks that use them. Both pad outputs are active-low drive enables for open-drain pads, so the block can pull a line low but never drives it high. A START or STOP seen on the bus aborts any byte in progress.

Top module: `i2c_byte_rx_ack`

## Requirements
- R1: After reset the register reads 0x00, `rx_full` is 0 and neither `scl_drive_low` nor `sda_drive_low` is asserted.
- R2: The register layout is: bits 1:0 filter select, bit 5 early-flag select, bit 6 inter-byte hold and bit 7 bus-type select. Each of these fields stores the written value and reads it back, and `filt_sel` and `smbus_sel` follow the stored fields.
- R3: Bit 3 (acknowledge value to send) takes the written value only when bit 4 is also 1 in the same write. Otherwise it keeps its previous value.
- R4: Writes to bit 2 (received acknowledge) are ignored. Bit 4 (acknowledge write enable) is not stored and always reads as 0.
- R5: With bit 5 at 0, `rx_full` rises after the ninth SCL rising edge and not after the eighth, and SCL is not held after the eighth falling edge. `rx_data` carries the byte in MSB-first order.
- R6: With bit 5 at 1, `rx_full` rises after the eighth SCL rising edge with the complete byte in `rx_data`. `scl_drive_low` is asserted from the eighth falling edge until a data read strobe.
- R7: From the eighth falling edge to the ninth falling edge, `sda_drive_low` equals the inverse of bit 3 (0 gives ACK by pulling low, 1 releases for NACK). It is deasserted after the ninth falling edge.
- R8: Bit 2 records the SDA line level sampled at the ninth SCL rising edge (0 for ACK, 1 for NACK).
- R9: With bit 6 at 1, `scl_drive_low` is asserted from the ninth falling edge until a data read strobe. With bit 6 at 0, no hold is applied there.
- R10: A `data_rd` pulse clears `rx_full` and releases any SCL hold in the next cycle.
- R11: A START or STOP condition (SDA changing while SCL is high) resets the bit count, so a byte that was cut off raises no flag and the next byte is received intact.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Synchronised SCL line level |
| sda_in | input | 1 | Synchronised SDA line level |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| data_rd | input | 1 | Data-register read strobe; clears the flag and releases holds |
| reg_rdata | output | 8 | Register read value |
| rx_data | output | 8 | Last received byte |
| rx_full | output | 1 | Receive-full flag |
| scl_drive_low | output | 1 | Pull SCL low (open-drain enable) |
| sda_drive_low | output | 1 | Pull SDA low (open-drain enable) |
| filt_sel | output | 2 | Stored filter stage select for the input filter |
| smbus_sel | output | 1 | Stored bus-type select |

## Verification
The hardest situations to reach are the two stretch points. There, the block's own drive on SCL must stop the bus, and the acknowledge value written while the bus is held must appear on SDA before the ninth clock. The bench models both lines as open-drain wired-AND between the peer and the design, so a hold really stops the peer's clock. Byte transfers run under all four combinations of flag timing and inter-byte hold, each with a different acknowledge setting. A repeated START issued in the middle of a byte then checks that the bit count restarts.

// File: rtl/i2c_rx_pkg.sv
package i2c_rx_pkg;

    localparam int REG_W      = 8;
    localparam int FILT_LSB   = 0;
    localparam int FILT_W     = 2;
    localparam int ACKR_BIT   = 2;
    localparam int ACKT_BIT   = 3;
    localparam int ACKWE_BIT  = 4;
    localparam int EARLY_BIT  = 5;
    localparam int HOLD_BIT   = 6;
    localparam int SMB_BIT    = 7;

    typedef struct packed {
        logic [FILT_W-1:0] filt;
        logic              ackt;
        logic              early;
        logic              hold_between;
        logic              smb;
    } cfg_t;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic bus_cond;
    } line_ev_t;

endpackage

// File: rtl/i2c_rx_line_events.sv
module i2c_rx_line_events
    import i2c_rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     scl_in,
    input  logic     sda_in,
    output line_ev_t ev
);

    typedef struct packed {
        logic scl;
        logic sda;
    } prev_t;

    prev_t prev_d, prev_q;

    always_comb begin
        prev_d     = prev_q;
        prev_d.scl = scl_in;
        prev_d.sda = sda_in;

        ev.scl_rise = scl_in & ~prev_q.scl;
        ev.scl_fall = ~scl_in & prev_q.scl;
        // SDA moving while SCL stays high marks START or STOP
        ev.bus_cond = scl_in & prev_q.scl & (sda_in ^ prev_q.sda);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '{scl: 1'b1, sda: 1'b1};
        end else begin
            prev_q <= prev_d;
        end
    end

endmodule

// File: rtl/i2c_rx_cfg_reg.sv
module i2c_rx_cfg_reg
    import i2c_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    input  logic             ackr_load,
    input  logic             ackr_val,
    output cfg_t             cfg,
    output logic [REG_W-1:0] rdata
);

    typedef struct packed {
        cfg_t cfg;
        logic ackr;
    } reg_state_t;

    reg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr) begin
            st_d.cfg.filt         = wdata[FILT_LSB +: FILT_W];
            st_d.cfg.early        = wdata[EARLY_BIT];
            st_d.cfg.hold_between = wdata[HOLD_BIT];
            st_d.cfg.smb          = wdata[SMB_BIT];
            if (wdata[ACKWE_BIT]) begin
                st_d.cfg.ackt = wdata[ACKT_BIT];
            end
        end
        if (ackr_load) begin
            st_d.ackr = ackr_val;
        end

        rdata                       = '0;
        rdata[FILT_LSB +: FILT_W]   = st_q.cfg.filt;
        rdata[ACKR_BIT]             = st_q.ackr;
        rdata[ACKT_BIT]             = st_q.cfg.ackt;
        rdata[EARLY_BIT]            = st_q.cfg.early;
        rdata[HOLD_BIT]             = st_q.cfg.hold_between;
        rdata[SMB_BIT]              = st_q.cfg.smb;

        cfg = st_q.cfg;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assert_ackt_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !wdata[ACKWE_BIT]) |=> $stable(st_q.cfg.ackt));

    assert_ackr_readonly_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !ackr_load) |=> $stable(st_q.ackr));

endmodule

// File: rtl/i2c_rx_byte_engine.sv
module i2c_rx_byte_engine
    import i2c_rx_pkg::*;
#(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  line_ev_t        ev,
    input  logic            sda_in,
    input  logic            early,
    input  logic            hold_between,
    input  logic            ackt,
    input  logic            data_rd,
    output logic [BITS-1:0] rx_data,
    output logic            rx_full,
    output logic            scl_low,
    output logic            sda_low,
    output logic            ackr_load,
    output logic            ackr_val
);

    localparam int CNT_W = $clog2(BITS + 2);
    localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(BITS - 1);
    localparam logic [CNT_W-1:0] DATA_DONE = CNT_W'(BITS);
    localparam logic [CNT_W-1:0] ACK_DONE  = CNT_W'(BITS + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [BITS-1:0]  shreg;
        logic [BITS-1:0]  data;
        logic             full;
        logic             hold;
        logic             ack_phase;
    } eng_t;

    eng_t st_d, st_q;
    logic [BITS-1:0] shifted;

    always_comb begin
        st_d      = st_q;
        ackr_load = 1'b0;
        ackr_val  = sda_in;
        shifted   = {st_q.shreg[BITS-2:0], sda_in};

        if (data_rd) begin
            st_d.full = 1'b0;
            st_d.hold = 1'b0;
        end

        if (ev.bus_cond) begin
            st_d.cnt       = '0;
            st_d.hold      = 1'b0;
            st_d.ack_phase = 1'b0;
        end else if (ev.scl_rise) begin
            if (st_q.cnt < DATA_DONE) begin
                st_d.shreg = shifted;
                st_d.cnt   = st_q.cnt + 1'b1;
                if (st_q.cnt == LAST_DATA && early) begin
                    st_d.full = 1'b1;
                    st_d.data = shifted;
                end
            end else if (st_q.cnt == DATA_DONE) begin
                st_d.cnt  = ACK_DONE;
                ackr_load = 1'b1;
                if (!early) begin
                    st_d.full = 1'b1;
                    st_d.data = st_q.shreg;
                end
            end
        end else if (ev.scl_fall) begin
            if (st_q.cnt == DATA_DONE) begin
                st_d.ack_phase = 1'b1;
                if (early) begin
                    st_d.hold = 1'b1;
                end
            end else if (st_q.cnt == ACK_DONE) begin
                st_d.ack_phase = 1'b0;
                st_d.cnt       = '0;
                if (hold_between) begin
                    st_d.hold = 1'b1;
                end
            end
        end

        rx_data = st_q.data;
        rx_full = st_q.full;
        scl_low = st_q.hold;
        sda_low = st_q.ack_phase & ~ackt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assert_flag_after_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.full) |-> $past(ev.scl_rise));

    assert_hold_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.hold) |-> $past(ev.scl_fall));

    assert_read_releases_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !ev.scl_fall) |=> (!scl_low && !rx_full));

    assert_cond_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ev.bus_cond |=> (st_q.cnt == '0 && !st_q.hold));

endmodule

// File: rtl/i2c_byte_rx_ack.sv
module i2c_byte_rx_ack
    import i2c_rx_pkg::*;
#(
    parameter int BITS_PER_BYTE = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     scl_in,
    input  logic                     sda_in,
    input  logic                     reg_wr,
    input  logic [REG_W-1:0]         reg_wdata,
    input  logic                     data_rd,
    output logic [REG_W-1:0]         reg_rdata,
    output logic [BITS_PER_BYTE-1:0] rx_data,
    output logic                     rx_full,
    output logic                     scl_drive_low,
    output logic                     sda_drive_low,
    output logic [FILT_W-1:0]        filt_sel,
    output logic                     smbus_sel
);

    line_ev_t ev;
    cfg_t     cfg;
    logic     ackr_load;
    logic     ackr_val;

    i2c_rx_line_events u_events (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .ev     (ev)
    );

    i2c_rx_cfg_reg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (reg_wr),
        .wdata     (reg_wdata),
        .ackr_load (ackr_load),
        .ackr_val  (ackr_val),
        .cfg       (cfg),
        .rdata     (reg_rdata)
    );

    i2c_rx_byte_engine #(.BITS(BITS_PER_BYTE)) u_engine (
        .clk          (clk),
        .rst_n        (rst_n),
        .ev           (ev),
        .sda_in       (sda_in),
        .early        (cfg.early),
        .hold_between (cfg.hold_between),
        .ackt         (cfg.ackt),
        .data_rd      (data_rd),
        .rx_data      (rx_data),
        .rx_full      (rx_full),
        .scl_low      (scl_drive_low),
        .sda_low      (sda_drive_low),
        .ackr_load    (ackr_load),
        .ackr_val     (ackr_val)
    );

    assign filt_sel  = cfg.filt;
    assign smbus_sel = cfg.smb;

endmodule

// File: tb/i2c_byte_rx_ack_tb.sv
module i2c_byte_rx_ack_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       scl_peer, sda_peer;
    logic       reg_wr, data_rd;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata, rx_data;
    logic       rx_full, scl_drive_low, sda_drive_low, smbus_sel;
    logic [1:0] filt_sel;
    logic       scl_line, sda_line;

    int errors = 0;
    int checks = 0;
    logic [7:0] exp_q[$];

    always #5 clk = ~clk;

    // open-drain wired-AND of peer and design
    assign scl_line = scl_peer & ~scl_drive_low;
    assign sda_line = sda_peer & ~sda_drive_low;

    i2c_byte_rx_ack u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_in        (scl_line),
        .sda_in        (sda_line),
        .reg_wr        (reg_wr),
        .reg_wdata     (reg_wdata),
        .data_rd       (data_rd),
        .reg_rdata     (reg_rdata),
        .rx_data       (rx_data),
        .rx_full       (rx_full),
        .scl_drive_low (scl_drive_low),
        .sda_drive_low (sda_drive_low),
        .filt_sel      (filt_sel),
        .smbus_sel     (smbus_sel)
    );

    task automatic check_eq(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic reg_write(input logic [7:0] v);
        reg_wr = 1'b1; reg_wdata = v; tick(1);
        reg_wr = 1'b0; tick(1);
    endtask

    task automatic pulse_rd();
        data_rd = 1'b1; tick(1);
        data_rd = 1'b0; tick(1);
    endtask

    task automatic bus_start();
        sda_peer = 1'b1; tick(3);
        scl_peer = 1'b1; tick(3);
        sda_peer = 1'b0; tick(3);
        scl_peer = 1'b0; tick(3);
    endtask

    task automatic bus_stop();
        sda_peer = 1'b0; tick(3);
        scl_peer = 1'b1; tick(3);
        sda_peer = 1'b1; tick(3);
    endtask

    // driver: pushes expected byte, clocks it in, checks timing
    task automatic send_byte(input logic [7:0] b, input logic peer_ack,
                             input logic early, input logic hold_between,
                             input logic ackt);
        exp_q.push_back(b);
        for (int i = 7; i >= 0; i--) begin
            sda_peer = b[i]; tick(3);
            scl_peer = 1'b1; tick(3);
            if (i == 0) check_eq(early ? "R6 flag at 8th rise" : "R5 no flag at 8th rise",
                                 int'(rx_full), int'(early));
            scl_peer = 1'b0; tick(3);
        end
        check_eq(early ? "R6 hold after 8th fall" : "R5 no hold after 8th fall",
                 int'(scl_drive_low), int'(early));
        check_eq("R7 ack drive", int'(sda_drive_low), int'(!ackt));
        if (early) begin
            tick(5);
            check_eq("R6 hold kept", int'(scl_drive_low), 1);
            pulse_rd();
            check_eq("R10 hold released", int'(scl_drive_low), 0);
            check_eq("R10 flag cleared", int'(rx_full), 0);
        end
        sda_peer = peer_ack; tick(3);
        scl_peer = 1'b1; tick(3);
        check_eq("R5 flag at 9th rise", int'(rx_full), int'(!early));
        check_eq("R8 ack status", int'(reg_rdata[2]), int'(peer_ack & ackt));
        scl_peer = 1'b0; tick(3);
        check_eq("R7 sda released", int'(sda_drive_low), 0);
        check_eq("R9 inter-byte hold", int'(scl_drive_low), int'(hold_between));
        if (hold_between) begin
            tick(4);
            check_eq("R9 hold kept", int'(scl_drive_low), 1);
        end
        if (rx_full || hold_between) pulse_rd();
        check_eq("R10 released", int'(scl_drive_low), 0);
        check_eq("R10 cleared", int'(rx_full), 0);
    endtask

    // monitor: compares each new byte against the scoreboard
    initial begin
        logic prev_full;
        logic [7:0] e;
        prev_full = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n && rx_full && !prev_full) begin
                if (exp_q.size() == 0) begin
                    check_eq("R5 unexpected flag", int'(rx_data), 0 - 1);
                end else begin
                    e = exp_q.pop_front();
                    check_eq("R5 rx_data", int'(rx_data), int'(e));
                end
            end
            prev_full = rx_full;
        end
    end

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL R1 watchdog actual=timeout expected=finished");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; scl_peer = 1'b1; sda_peer = 1'b1;
        reg_wr = 1'b0; reg_wdata = '0; data_rd = 1'b0;
        tick(4);
        rst_n = 1'b1; tick(2);

        check_eq("R1 reg reset", int'(reg_rdata), 'h00);
        check_eq("R1 flag reset", int'(rx_full), 0);
        check_eq("R1 drives idle", int'({scl_drive_low, sda_drive_low}), 0);

        reg_write(8'hFF);
        check_eq("R2 all fields", int'(reg_rdata), 'hEB);
        check_eq("R2 filt_sel", int'(filt_sel), 3);
        check_eq("R2 smbus_sel", int'(smbus_sel), 1);
        reg_write(8'h03);
        check_eq("R3 ackt kept without enable", int'(reg_rdata), 'h0B);
        reg_write(8'h10);
        check_eq("R3 ackt cleared with enable", int'(reg_rdata), 'h00);
        reg_write(8'h04);
        check_eq("R4 bit2 ignored", int'(reg_rdata), 'h00);
        reg_write(8'h18);
        check_eq("R3 ackt set with enable", int'(reg_rdata), 'h08);

        // normal flag timing, ACK, no hold
        reg_write(8'h10);
        bus_start();
        send_byte(8'hA5, 1'b1, 1'b0, 1'b0, 1'b0);
        send_byte(8'h3C, 1'b1, 1'b0, 1'b0, 1'b0);

        // NACK value, hold between bytes
        reg_write(8'h58);
        send_byte(8'h81, 1'b0, 1'b0, 1'b1, 1'b1);
        send_byte(8'h7E, 1'b1, 1'b0, 1'b1, 1'b1);
        check_eq("R8 nack recorded", int'(reg_rdata[2]), 1);

        // early flag with hold at 8th clock
        reg_write(8'h30);
        send_byte(8'hC3, 1'b1, 1'b1, 1'b0, 1'b0);
        send_byte(8'h00, 1'b1, 1'b1, 1'b0, 1'b0);

        // both holds, NACK
        reg_write(8'h78);
        send_byte(8'hFF, 1'b0, 1'b1, 1'b1, 1'b1);

        // aborted byte followed by repeated START
        reg_write(8'h10);
        for (int i = 0; i < 3; i++) begin
            sda_peer = i[0]; tick(3);
            scl_peer = 1'b1; tick(3);
            scl_peer = 1'b0; tick(3);
        end
        bus_start();
        check_eq("R11 no flag on aborted byte", int'(rx_full), 0);
        send_byte(8'h5A, 1'b1, 1'b0, 1'b0, 1'b0);
        bus_stop();
        tick(4);
        check_eq("R11 scoreboard drained", exp_q.size(), 0);

        finish_run();
    end

endmodule